// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits between a processor bus and a set of downstream targets. It holds a bank of eight programmable address windows. Each window has a control word, a base address and a pair of remap words, all loaded through a simple register-write port. Every cycle the block takes one incoming address and reports whether any enabled window claims it, which window won, that window's target and attribute codes, and the translated output address.

A window's size is a power of two between 64 KB and 4 GB. It is set by a thermometer mask counted from the least significant bit. Windows that carry remap registers replace the address bits above the window size with the remap base. Windows without remap registers pass the address through unchanged. An illegal size mask is flagged and disables the window. When several windows overlap, the lowest-numbered one wins and a multi-hit flag is raised.

Top module: `awd_top`

## Requirements
- R1: The write port selects a window with `wrWin` and a register with `wrFld`: 0 selects control, 1 selects base, 2 selects remap-low and 3 selects remap-high. A write on one rising edge is used by the lookup sampled on the next rising edge. The lookup sampled on the same edge as the write still uses the old value.
- R2: The control word has the enable bit at bit 0, the target code at bits 7:4, the attribute code at bits 15:8 and the size mask at bits 31:16. A window whose enable bit is 0 never hits.
- R3: A size mask made of k ones from bit 0 upward, followed by zeros, gives a window of 64 KB times 2^k bytes. An address hits when its bits above that size equal the same bits of the base. 0x00FF gives 16 MB and 0xFFFF gives the whole 4 GB space.
- R4: A size mask of 0x0000 gives a 64 KB window. The address then matches the base in bits 31:16.
- R5: If a size mask is not a run of ones starting at bit 0, `cfgErr` for that window is 1, whether or not the window is enabled. Such a window never hits.
- R6: For a window with remap registers, `addrOut` takes remap-low in the bits above the window size and the input address in the bits inside it. `addrOutHi` is that window's remap-high. When remap-low equals the base, `addrOut` equals the input address.
- R7: Windows without remap registers are set by parameter `HAS_REMAP`, whose default gives remap registers to windows 0 to 3 only. For those windows `addrOut` equals the input address and `addrOutHi` is 0, and writes to fields 2 and 3 have no effect.
- R8: When several enabled windows hit, the lowest-numbered one supplies index, target, attribute and translation, and `multiHit` is 1. `multiHit` is 0 when at most one window hits.
- R9: On a miss, `hit`, `multiHit`, `hitIdx`, `hitTarget`, `hitAttr` and `addrOutHi` are 0, and `addrOut` equals the input address.
- R10: All lookup outputs are registered: they describe the address sampled on the previous rising edge. An active-low reset clears every register of every window, so all windows are disabled, and it clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrWin | input | 3 | Window selected by a write |
| wrFld | input | 2 | Register selected by a write (0 control, 1 base, 2 remap-low, 3 remap-high) |
| wrData | input | 32 | Write data |
| addrIn | input | 32 | Address to decode |
| hit | output | 1 | Some enabled window claimed the previous address |
| multiHit | output | 1 | More than one window claimed it |
| hitIdx | output | 3 | Index of the winning window |
| hitTarget | output | 4 | Target code of the winning window |
| hitAttr | output | 8 | Attribute code of the winning window |
| addrOut | output | 32 | Translated address |
| addrOutHi | output | 32 | Upper address word from remap-high |
| cfgErr | output | 8 | Per-window illegal size mask flag |

## Verification
The assertions assume that `wrWin`, `wrFld`, `wrData` and `addrIn` are known, non-X values that stay stable around each rising edge. They also assume that at most one register is written per cycle, which the single write port already enforces. The bench changes every input only on the falling clock edge. It drives fully specified values, including randomly chosen size masks that are sometimes non-contiguous, so that the configuration-error path is reached legally. Addresses are drawn both at random and at the first and last byte of each programmed window.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int GRAN_BITS = 16;
  localparam int SIZE_W    = 16;
  localparam int TGT_W     = 4;
  localparam int ATTR_W    = 8;
  localparam int FLD_W     = 2;

  typedef enum logic [FLD_W-1:0] {
    FLD_CTRL     = 2'd0,
    FLD_BASE     = 2'd1,
    FLD_REMAP_LO = 2'd2,
    FLD_REMAP_HI = 2'd3
  } fld_e;

  typedef struct packed {
    logic ctrlWr;
    logic baseWr;
    logic remapLoWr;
    logic remapHiWr;
  } wrStrobe_t;

  typedef struct packed {
    logic [SIZE_W-1:0] sizeMask;
    logic [ATTR_W-1:0] attr;
    logic [TGT_W-1:0]  target;
    logic [2:0]        rsvd;
    logic              enable;
  } winCtrl_t;
endpackage

// File: rtl/awd_ctrl.sv
module awd_ctrl
  import awd_pkg::*;
#(
  parameter int NWIN  = 8,
  localparam int IDX_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrWin,
  input  logic [FLD_W-1:0] wrFld,
  output logic [NWIN-1:0]  winHot,
  output wrStrobe_t        strobe
);
  always_comb begin
    winHot = '0;
    if (wrEn) winHot = NWIN'(1) << wrWin;
  end

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (fld_e'(wrFld))
        FLD_CTRL:     strobe.ctrlWr    = 1'b1;
        FLD_BASE:     strobe.baseWr    = 1'b1;
        FLD_REMAP_LO: strobe.remapLoWr = 1'b1;
        FLD_REMAP_HI: strobe.remapHiWr = 1'b1;
        default:      strobe = '0;
      endcase
    end
  end

  // R1: one register of one window per write, nothing when idle
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe) && $onehot0(winHot))
    else $error("more than one write strobe");
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strobe == '0 && winHot == '0))
    else $error("strobe without write enable");
endmodule

// File: rtl/awd_window.sv
module awd_window
  import awd_pkg::*;
#(
  parameter bit HAS_REMAP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selThis,
  input  wrStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              hit,
  output logic              cfgErr,
  output logic [TGT_W-1:0]  target,
  output logic [ATTR_W-1:0] attr,
  output logic [ADDR_W-1:0] xlatAddr,
  output logic [ADDR_W-1:0] xlatHi
);
  localparam logic [ADDR_W-1:0] LOW_MASK = {ADDR_W{1'b1}} >> (ADDR_W - GRAN_BITS);

  winCtrl_t          ctrlQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] dcMask;
  logic              sizeOk;
  logic              unusedRsvd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      baseQ <= '0;
    end else if (selThis) begin
      if (strobe.ctrlWr) ctrlQ <= winCtrl_t'(wrData);
      if (strobe.baseWr) baseQ <= ADDR_W'(wrData);
    end
  end

  // contiguous run from bit 0: adding one clears every set bit
  assign sizeOk = (ctrlQ.sizeMask & (ctrlQ.sizeMask + SIZE_W'(1))) == '0;
  assign dcMask = (ADDR_W'(ctrlQ.sizeMask) << GRAN_BITS) | LOW_MASK;
  assign hit    = ctrlQ.enable && sizeOk &&
                  ((addrIn & ~dcMask) == (baseQ & ~dcMask));
  assign cfgErr = !sizeOk;
  assign target = ctrlQ.target;
  assign attr   = ctrlQ.attr;
  assign unusedRsvd = ^ctrlQ.rsvd;

  generate
    if (HAS_REMAP) begin : g_remap
      logic [ADDR_W-1:0] remapLoQ;
      logic [ADDR_W-1:0] remapHiQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          remapLoQ <= '0;
          remapHiQ <= '0;
        end else if (selThis) begin
          if (strobe.remapLoWr) remapLoQ <= ADDR_W'(wrData);
          if (strobe.remapHiWr) remapHiQ <= ADDR_W'(wrData);
        end
      end
      assign xlatAddr = (remapLoQ & ~dcMask) | (addrIn & dcMask);
      assign xlatHi   = remapHiQ;
    end else begin : g_pass
      logic unusedRemapWr;
      assign unusedRemapWr = strobe.remapLoWr | strobe.remapHiWr;
      assign xlatAddr = addrIn;
      assign xlatHi   = '0;
    end
  endgenerate

  p_disabled_nohit_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.enable |-> !hit)
    else $error("disabled window hit");
  p_cfgerr_nohit_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !hit)
    else $error("window with bad size hit");
  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (selThis && strobe.ctrlWr) |=> (ctrlQ == winCtrl_t'($past(wrData))))
    else $error("control write lost");
  p_base_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (selThis && strobe.baseWr) |=> (baseQ == ADDR_W'($past(wrData))))
    else $error("base write lost");
endmodule

// File: rtl/awd_select.sv
module awd_select
  import awd_pkg::*;
#(
  parameter int NWIN  = 8,
  localparam int IDX_W = $clog2(NWIN)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NWIN-1:0]                winHit,
  input  logic [NWIN-1:0][TGT_W-1:0]     winTgt,
  input  logic [NWIN-1:0][ATTR_W-1:0]    winAttr,
  input  logic [NWIN-1:0][ADDR_W-1:0]    winXlat,
  input  logic [NWIN-1:0][ADDR_W-1:0]    winXlatHi,
  input  logic [ADDR_W-1:0]              addrIn,
  output logic                           hitQ,
  output logic                           multiQ,
  output logic [IDX_W-1:0]               idxQ,
  output logic [TGT_W-1:0]               tgtQ,
  output logic [ATTR_W-1:0]              attrQ,
  output logic [ADDR_W-1:0]              addrOutQ,
  output logic [ADDR_W-1:0]              addrOutHiQ
);
  logic [IDX_W-1:0] selIdx;
  logic             anyHit;
  logic             manyHit;

  always_comb begin
    selIdx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (winHit[i]) selIdx = IDX_W'(i);
    end
  end

  assign anyHit  = |winHit;
  assign manyHit = (winHit & (winHit - NWIN'(1))) != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ       <= 1'b0;
      multiQ     <= 1'b0;
      idxQ       <= '0;
      tgtQ       <= '0;
      attrQ      <= '0;
      addrOutQ   <= '0;
      addrOutHiQ <= '0;
    end else if (anyHit) begin
      hitQ       <= 1'b1;
      multiQ     <= manyHit;
      idxQ       <= selIdx;
      tgtQ       <= winTgt[selIdx];
      attrQ      <= winAttr[selIdx];
      addrOutQ   <= winXlat[selIdx];
      addrOutHiQ <= winXlatHi[selIdx];
    end else begin
      hitQ       <= 1'b0;
      multiQ     <= 1'b0;
      idxQ       <= '0;
      tgtQ       <= '0;
      attrQ      <= '0;
      addrOutQ   <= addrIn;
      addrOutHiQ <= '0;
    end
  end

  p_multi_needs_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    multiQ |-> hitQ)
    else $error("multi-hit without hit");
  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    hitQ |-> ((($past(winHit) >> idxQ) & NWIN'(1)) == NWIN'(1)) &&
             (($past(winHit) & ((NWIN'(1) << idxQ) - NWIN'(1))) == '0))
    else $error("winner is not the lowest hitting window");
  p_hit_tracks_r10: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |=> hitQ)
    else $error("hit not registered");
  p_miss_passthru_r9: assert property (@(posedge clk) disable iff (!rstN)
    !anyHit |=> (!hitQ && !multiQ && addrOutHiQ == '0 && addrOutQ == $past(addrIn)))
    else $error("miss output wrong");
endmodule

// File: rtl/awd_top.sv
module awd_top
  import awd_pkg::*;
#(
  parameter int NWIN = 8,
  parameter logic [NWIN-1:0] HAS_REMAP = NWIN'(8'h0F),
  localparam int IDX_W = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrWin,
  input  logic [FLD_W-1:0]  wrFld,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              hit,
  output logic              multiHit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [TGT_W-1:0]  hitTarget,
  output logic [ATTR_W-1:0] hitAttr,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] addrOutHi,
  output logic [NWIN-1:0]   cfgErr
);
  logic [NWIN-1:0]              winHot;
  wrStrobe_t                    strobe;
  logic [NWIN-1:0]              winHit;
  logic [NWIN-1:0][TGT_W-1:0]   winTgt;
  logic [NWIN-1:0][ATTR_W-1:0]  winAttr;
  logic [NWIN-1:0][ADDR_W-1:0]  winXlat;
  logic [NWIN-1:0][ADDR_W-1:0]  winXlatHi;

  awd_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWin(wrWin), .wrFld(wrFld),
    .winHot(winHot), .strobe(strobe)
  );

  generate
    for (genvar g = 0; g < NWIN; g++) begin : g_win
      awd_window #(.HAS_REMAP(HAS_REMAP[g])) u_win (
        .clk(clk), .rstN(rstN), .selThis(winHot[g]), .strobe(strobe),
        .wrData(wrData), .addrIn(addrIn), .hit(winHit[g]), .cfgErr(cfgErr[g]),
        .target(winTgt[g]), .attr(winAttr[g]), .xlatAddr(winXlat[g]),
        .xlatHi(winXlatHi[g])
      );
    end
  endgenerate

  awd_select #(.NWIN(NWIN)) u_sel (
    .clk(clk), .rstN(rstN), .winHit(winHit), .winTgt(winTgt), .winAttr(winAttr),
    .winXlat(winXlat), .winXlatHi(winXlatHi), .addrIn(addrIn),
    .hitQ(hit), .multiQ(multiHit), .idxQ(hitIdx), .tgtQ(hitTarget),
    .attrQ(hitAttr), .addrOutQ(addrOut), .addrOutHiQ(addrOutHi)
  );
endmodule

// File: tb/awd_top_bench.sv
module awd_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;
  localparam logic [7:0] REMAP = 8'h0F;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrWin = '0;
  logic [1:0] wrFld = '0;
  logic [31:0] wrData = '0;
  logic [31:0] addrIn = '0;
  logic hit, multiHit;
  logic [2:0] hitIdx;
  logic [3:0] hitTarget;
  logic [7:0] hitAttr;
  logic [31:0] addrOut, addrOutHi;
  logic [7:0] cfgErr;

  awd_top u_awd_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWin(wrWin), .wrFld(wrFld),
    .wrData(wrData), .addrIn(addrIn), .hit(hit), .multiHit(multiHit),
    .hitIdx(hitIdx), .hitTarget(hitTarget), .hitAttr(hitAttr),
    .addrOut(addrOut), .addrOutHi(addrOutHi), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string curReq = "R10";

  // behavioural model state
  logic [31:0] mCtrl [NWIN];
  logic [31:0] mBase [NWIN];
  logic [31:0] mRlo  [NWIN];
  logic [31:0] mRhi  [NWIN];
  logic eHit, eMulti;
  logic [2:0] eIdx;
  logic [3:0] eTgt;
  logic [7:0] eAttr;
  logic [31:0] eOut, eOutHi;
  logic [7:0] eCfg;

  function automatic int onesRun(logic [15:0] s);
    int k = 0;
    while (k < 16 && s[k]) k++;
    for (int j = k; j < 16; j++) if (s[j]) return -1;
    return k;
  endfunction

  function automatic longint winBytes(int w);
    return longint'(65536) << onesRun(mCtrl[w][31:16]);
  endfunction

  function automatic bit matchW(int w, logic [31:0] a);
    longint sz;
    if (!mCtrl[w][0]) return 1'b0;
    if (onesRun(mCtrl[w][31:16]) < 0) return 1'b0;
    sz = winBytes(w);
    return ({32'h0, a} / sz) == ({32'h0, mBase[w]} / sz);
  endfunction

  function automatic logic [31:0] xlatW(int w, logic [31:0] a);
    longint sz;
    longint r;
    if (!REMAP[w]) return a;
    sz = winBytes(w);
    r = ({32'h0, mRlo[w]} / sz) * sz + ({32'h0, a} % sz);
    return r[31:0];
  endfunction

  task automatic modelLookup(input logic [31:0] a);
    int first;
    int cnt;
    first = -1;
    cnt = 0;
    for (int w = 0; w < NWIN; w++) begin
      if (matchW(w, a)) begin
        cnt++;
        if (first < 0) first = w;
      end
    end
    if (first < 0) begin
      eHit = 0; eMulti = 0; eIdx = 0; eTgt = 0; eAttr = 0; eOut = a; eOutHi = 0;
    end else begin
      eHit = 1;
      eMulti = (cnt > 1);
      eIdx = 3'(first);
      eTgt = mCtrl[first][7:4];
      eAttr = mCtrl[first][15:8];
      eOut = xlatW(first, a);
      eOutHi = REMAP[first] ? mRhi[first] : 32'h0;
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NWIN; w++) begin
        mCtrl[w] = 0; mBase[w] = 0; mRlo[w] = 0; mRhi[w] = 0;
      end
      eHit = 0; eMulti = 0; eIdx = 0; eTgt = 0; eAttr = 0; eOut = 0; eOutHi = 0;
    end else begin
      modelLookup(addrIn);  // uses state before this edge's write (R1)
      if (wrEn) begin
        case (wrFld)
          2'd0: mCtrl[wrWin] = wrData;
          2'd1: mBase[wrWin] = wrData;
          2'd2: if (REMAP[wrWin]) mRlo[wrWin] = wrData;
          default: if (REMAP[wrWin]) mRhi[wrWin] = wrData;
        endcase
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      for (int w = 0; w < NWIN; w++) eCfg[w] = (onesRun(mCtrl[w][31:16]) < 0);
      checks++;
      if ({hit, multiHit, hitIdx, hitTarget, hitAttr, addrOut, addrOutHi, cfgErr} !==
          {eHit, eMulti, eIdx, eTgt, eAttr, eOut, eOutHi, eCfg}) begin
        errors++;
        $display("FAIL %s t=%0t actual hit=%b multi=%b idx=%0d tgt=%h attr=%h out=%h hi=%h cfg=%h expected hit=%b multi=%b idx=%0d tgt=%h attr=%h out=%h hi=%h cfg=%h",
                 curReq, $time, hit, multiHit, hitIdx, hitTarget, hitAttr, addrOut, addrOutHi, cfgErr,
                 eHit, eMulti, eIdx, eTgt, eAttr, eOut, eOutHi, eCfg);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(bit we, int w, int f, logic [31:0] d, logic [31:0] a);
    @(negedge clk);
    wrEn = we; wrWin = 3'(w); wrFld = 2'(f); wrData = d; addrIn = a;
  endtask

  task automatic wr(int w, int f, logic [31:0] d);
    step(1'b1, w, f, d, addrIn);
  endtask

  task automatic lk(logic [31:0] a);
    step(1'b0, 0, 0, 32'h0, a);
  endtask

  function automatic logic [31:0] mkCtrl(bit en, int tgt, int at, int sz);
    return {16'(sz), 8'(at), 4'(tgt), 3'b000, en};
  endfunction

  initial begin
    #2 rstN = 1'b0;
    curReq = "R10";  // reset state: everything cleared
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    lk(32'h8000_0000);
    lk(32'h0000_0000);  // R10: all windows disabled after reset

    curReq = "R1";
    wr(0, 0, mkCtrl(1, 3, 8'hE8, 16'h0FFF));
    wr(0, 1, 32'h8000_0000);
    wr(0, 2, 32'h8000_0000);
    wr(0, 3, 32'h0);
    wr(1, 1, 32'h9000_0000);
    wr(1, 2, 32'h1234_0000);
    wr(1, 3, 32'h0000_000A);
    wr(1, 0, mkCtrl(1, 5, 8'h11, 16'h0000));
    wr(2, 0, mkCtrl(1, 1, 8'h2F, 16'h07FF));
    wr(2, 1, 32'hD000_0000);
    wr(2, 2, 32'h4000_0000);
    wr(4, 0, mkCtrl(1, 6, 8'h0F, 16'h00FF));
    wr(4, 1, 32'hF000_0000);
    wr(4, 2, 32'h1234_0000);  // R7: ignored
    wr(4, 3, 32'h5555_5555);  // R7: ignored
    // R1: write and lookup on the same edge sees the old state
    wr(3, 1, 32'hA000_0000);
    step(1'b1, 3, 0, mkCtrl(1, 2, 8'h33, 16'h0001), 32'hA001_2345);
    lk(32'hA001_2345);
    lk(32'hA001_2345);

    curReq = "R6";
    lk(32'h8000_0000); lk(32'h8ABC_DEF0); lk(32'h8FFF_FFFF);
    curReq = "R4";
    lk(32'h9000_0000); lk(32'h9000_FFFF); lk(32'h9001_0000); lk(32'h8FFF_0000);
    curReq = "R3";
    lk(32'hD000_0000); lk(32'hD7FF_FFFF); lk(32'hD800_0000); lk(32'hCFFF_FFFF);
    curReq = "R7";
    lk(32'hF000_0000); lk(32'hF0FF_FFFF); lk(32'hF100_0000);

    curReq = "R2";
    wr(3, 0, mkCtrl(0, 2, 8'h33, 16'h0001));
    lk(32'hA000_0000); lk(32'hA001_FFFF);

    curReq = "R5";
    wr(5, 1, 32'hE000_0000);
    wr(5, 0, mkCtrl(1, 7, 8'h77, 16'h0005));
    lk(32'hE000_0000); lk(32'hE000_0000);
    wr(6, 0, mkCtrl(0, 7, 8'h77, 16'h8000));  // flagged while disabled
    lk(32'hE000_1000);

    curReq = "R8";
    wr(6, 1, 32'h8000_0000);
    wr(6, 0, mkCtrl(1, 9, 8'h99, 16'h00FF));
    lk(32'h8000_1234); lk(32'h80FF_FFFF); lk(32'h8100_0000);
    wr(7, 1, 32'hF000_0000);
    wr(7, 0, mkCtrl(1, 4, 8'h44, 16'h0000));
    lk(32'hF000_8000);  // 4 and 7 overlap, 4 wins

    curReq = "R9";
    lk(32'h0000_0000); lk(32'h7FFF_FFFF); lk(32'hC000_0000);

    curReq = "R3";  // random programming and lookups
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      if (sel < 20) begin
        int w;
        int f;
        logic [31:0] d;
        w = int'($urandom_range(0, 7));
        f = int'($urandom_range(0, 3));
        d = $urandom();
        if (f == 0) begin
          if ($urandom_range(0, 3) != 0)
            d[31:16] = 16'((32'h1 << $urandom_range(0, 16)) - 1);
          d[0] = ($urandom_range(0, 4) != 0);
        end
        wr(w, f, d);
      end else if (sel < 60) begin
        int w;
        w = int'($urandom_range(0, 7));
        lk(mBase[w] ^ (32'h1 << $urandom_range(0, 31)));
      end else begin
        lk($urandom());
      end
    end
    lk(32'h0);

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule